// File: doc/BRIEF.md
# Sprite and Playfield Overlap Detector

This block watches the pixel stream of a display pipeline and records which display objects overlap. On every cycle that carries a pixel, it looks at six bit-plane bits and eight sprite-active bits. It folds them into two playfields and four sprite groups, then works out which of the fifteen possible object pairs are drawn at the same spot. The pairs seen are gathered into a sticky register. Software reads that register once per frame, or as often as it likes, and the read also empties it.

A 16-bit control word shapes the comparison. Each bit-plane can be left out of playfield detection. If it is included, it must show a chosen value for its playfield to count as present. Planes 1, 3 and 5 make up playfield 1 and planes 2, 4 and 6 make up playfield 2. Each odd sprite can be merged into the even sprite just below it, so the two act as one group.

The control word and the register both reset to zero. With every plane excluded, both playfields count as present on every valid pixel.

Top module: `sprite_pf_collide`

## Requirements
- R1: After reset the collision register reads zero and the control word is zero.
- R2: Control word layout, with plane k carried on plane_bits[k-1]. Bits 15..12 merge sprites 7, 5, 3 and 1 into their groups. Bits 11..6 include planes 6..1 in playfield detection. Bits 5..0 hold the value each of planes 6..1 must show.
- R3: Sprite group g (g = 0..3) is active when sprite 2g is active, or when sprite 2g+1 is active and its merge bit (control bit 12+g) is set.
- R4: Playfield 1 is present when each included odd plane (1, 3, 5) equals its match value. Playfield 2 is present under the same rule for the even planes (2, 4, 6).
- R5: An excluded plane never blocks presence. A playfield with none of its planes included is present on every valid pixel.
- R6: Playfield bits of the register: bit 0 marks playfield 1 with playfield 2. Bits 1+g mark playfield 1 with group g. Bits 5+g mark playfield 2 with group g.
- R7: Sprite group pair bits: bit 9 is groups 0-1, bit 10 is 0-2, bit 11 is 0-3, bit 12 is 1-2, bit 13 is 1-3 and bit 14 is 2-3. Bit 15 is always zero.
- R8: Register bits are sticky. Each bit is the OR of all hits seen since the last read and stays set until a read.
- R9: In a cycle with rd_stb high, collide_q shows the value being read. The register is then cleared, except that hits from a valid pixel in the same cycle are kept in the cleared register.
- R10: Pixels with pix_valid low add nothing to the register.
- R11: A control write takes effect for pixels in the cycles that follow it. A pixel in the same cycle as the write is judged under the old control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| plane_bits | input | 6 | Bit-plane values of the current pixel; bit k-1 is plane k |
| spr_on | input | 8 | Sprite-active bits; bit n is sprite n |
| pix_valid | input | 1 | Marks a cycle carrying a pixel to evaluate |
| ctl_we | input | 1 | Writes ctl_wdata into the control word |
| ctl_wdata | input | 16 | Control word value to write |
| rd_stb | input | 1 | Read strobe: current value is read, register clears |
| collide_q | output | 16 | Sticky collision register; bit 15 is zero |

## Verification
Three things can land on the same clock edge: a read that clears the register, a valid pixel that sets new bits, and a control write that changes how the next pixel is judged. The random phase raises rd_stb, pix_valid and ctl_we independently. Directed cases also force each pairing: a read together with a hit, a read on an idle cycle, and a control write together with a pixel. Each outcome is judged against a bench model. The model clears first, then ORs in the hits computed under the control word that was in force before the edge.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int NPLANE  = 6;
  localparam int NSPR    = 8;
  localparam int NGRP    = NSPR / 2;
  localparam int NPF_PL  = NPLANE / 2;
  localparam int CW      = NGRP + 2 * NPLANE;
  localparam int HIT_W   = 16;
  localparam int PF_BASE = 1;
  localparam int PAIR_BASE = PF_BASE + 2 * NGRP;

  typedef struct packed {
    logic [NGRP-1:0]   spr_merge;
    logic [NPLANE-1:0] plane_en;
    logic [NPLANE-1:0] plane_val;
  } ctl_t;

  // Presence of one playfield: every included plane must equal its value.
  function automatic logic pf_present(input logic [NPF_PL-1:0] bits,
                                      input logic [NPF_PL-1:0] en,
                                      input logic [NPF_PL-1:0] val);
    return ((bits ^ val) & en) == '0;
  endfunction

  // Register bit for sprite group pair (a,b), a < b.
  function automatic int pair_idx(input int a, input int b);
    return PAIR_BASE + (a * (2 * NGRP - a - 1)) / 2 + (b - a - 1);
  endfunction
endpackage

// File: rtl/ovl_ctl_reg.sv
module ovl_ctl_reg
  import ovl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CW-1:0] wdata,
  output ctl_t          ctl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  ctl_q <= '0;
    else if (we) ctl_q <= ctl_t'(wdata);
  end
endmodule

// File: rtl/ovl_pf_detect.sv
module ovl_pf_detect
  import ovl_pkg::*;
(
  input  logic [NPF_PL-1:0] bits,
  input  logic [NPF_PL-1:0] en,
  input  logic [NPF_PL-1:0] val,
  output logic              present
);
  assign present = pf_present(bits, en, val);
endmodule

// File: rtl/ovl_spr_group.sv
module ovl_spr_group
  import ovl_pkg::*;
(
  input  logic [NSPR-1:0] spr_on,
  input  logic [NGRP-1:0] merge,
  output logic [NGRP-1:0] grp_on
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_on[g] = spr_on[2*g] | (merge[g] & spr_on[2*g+1]);
  end
endmodule

// File: rtl/ovl_hit_map.sv
module ovl_hit_map
  import ovl_pkg::*;
(
  input  logic             pf1_on,
  input  logic             pf2_on,
  input  logic [NGRP-1:0]  grp_on,
  output logic [HIT_W-1:0] hits
);
  assign hits[0] = pf1_on & pf2_on;
  for (genvar g = 0; g < NGRP; g++) begin : g_pf
    assign hits[PF_BASE + g]        = pf1_on & grp_on[g];
    assign hits[PF_BASE + NGRP + g] = pf2_on & grp_on[g];
  end
  for (genvar a = 0; a < NGRP; a++) begin : g_a
    for (genvar b = a + 1; b < NGRP; b++) begin : g_b
      assign hits[pair_idx(a, b)] = grp_on[a] & grp_on[b];
    end
  end
  assign hits[HIT_W-1] = 1'b0;
endmodule

// File: rtl/sprite_pf_collide.sv
module sprite_pf_collide
  import ovl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPLANE-1:0] plane_bits,
  input  logic [NSPR-1:0]   spr_on,
  input  logic              pix_valid,
  input  logic              ctl_we,
  input  logic [CW-1:0]     ctl_wdata,
  input  logic              rd_stb,
  output logic [HIT_W-1:0]  collide_q
);
  ctl_t ctl_q;
  logic [NPF_PL-1:0] odd_bits, even_bits, odd_en, even_en, odd_val, even_val;
  logic pf1_on, pf2_on;
  logic [NGRP-1:0] grp_on;
  logic [HIT_W-1:0] pix_hits;
  logic [HIT_W-1:0] keep_q;

  ovl_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata), .ctl_q(ctl_q)
  );

  for (genvar k = 0; k < NPF_PL; k++) begin : g_split
    assign odd_bits[k]  = plane_bits[2*k];
    assign even_bits[k] = plane_bits[2*k+1];
    assign odd_en[k]    = ctl_q.plane_en[2*k];
    assign even_en[k]   = ctl_q.plane_en[2*k+1];
    assign odd_val[k]   = ctl_q.plane_val[2*k];
    assign even_val[k]  = ctl_q.plane_val[2*k+1];
  end

  ovl_pf_detect u_pf1 (.bits(odd_bits),  .en(odd_en),  .val(odd_val),  .present(pf1_on));
  ovl_pf_detect u_pf2 (.bits(even_bits), .en(even_en), .val(even_val), .present(pf2_on));

  ovl_spr_group u_grp (.spr_on(spr_on), .merge(ctl_q.spr_merge), .grp_on(grp_on));

  ovl_hit_map u_map (.pf1_on(pf1_on), .pf2_on(pf2_on), .grp_on(grp_on), .hits(pix_hits));

  assign keep_q = rd_stb ? '0 : collide_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         collide_q <= '0;
    else if (pix_valid) collide_q <= keep_q | pix_hits;
    else                collide_q <= keep_q;
  end

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ((collide_q & $past(collide_q)) == $past(collide_q)));
  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !pix_valid) |=> (collide_q == '0));
  // R9
  rd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && pix_valid) |=> (collide_q == $past(pix_hits)));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_valid && !rd_stb) |=> $stable(collide_q));
  // R5
  pf1_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_en == '0) |-> pf1_on);
  // R5
  pf2_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (even_en == '0) |-> pf2_on);
  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    // R3
    grp_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spr_on[2*g] |-> grp_on[g]);
  end
endmodule

// File: tb/sprite_pf_collide_tb_top.sv
`timescale 1ns/1ps
module sprite_pf_collide_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] plane_bits = '0;
  logic [7:0] spr_on = '0;
  logic pix_valid = 1'b0;
  logic ctl_we = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic rd_stb = 1'b0;
  logic [15:0] collide_q;

  int total = 0;
  int bad = 0;
  logic [15:0] m_ctl = '0;
  logic [15:0] m_reg = '0;

  always #2.5 clk = ~clk;

  sprite_pf_collide dut_i (
    .clk(clk), .rst_n(rst_n), .plane_bits(plane_bits), .spr_on(spr_on),
    .pix_valid(pix_valid), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .rd_stb(rd_stb), .collide_q(collide_q)
  );

  // Objects: 0 = playfield 1, 1 = playfield 2, 2..5 = sprite groups 0..3
  function automatic logic [15:0] exp_hits(input logic [15:0] c,
                                           input logic [5:0] pl,
                                           input logic [7:0] sp);
    logic [5:0] obj;
    logic [15:0] r;
    int k;
    obj = 6'b000011;
    for (int p = 1; p <= 6; p++)
      if (c[6 + p - 1] && (pl[p-1] != c[p-1])) obj[(p % 2 == 1) ? 0 : 1] = 1'b0;
    for (int g = 0; g < 4; g++)
      obj[2+g] = sp[2*g] || (sp[2*g+1] && c[12+g]);
    r = '0;
    r[0] = obj[0] & obj[1];
    for (int g = 0; g < 4; g++) begin
      r[1+g] = obj[0] & obj[2+g];
      r[5+g] = obj[1] & obj[2+g];
    end
    k = 9;
    for (int a = 0; a < 4; a++)
      for (int b = a + 1; b < 4; b++) begin
        r[k] = obj[2+a] & obj[2+b];
        k++;
      end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle, update the model at the edge, compare just after it.
  task automatic step(input string req, input logic [5:0] pl, input logic [7:0] sp,
                      input logic v, input logic we, input logic [15:0] wd, input logic rd);
    logic [15:0] h;
    plane_bits = pl; spr_on = sp; pix_valid = v; ctl_we = we; ctl_wdata = wd; rd_stb = rd;
    h = exp_hits(m_ctl, pl, sp);
    @(posedge clk);
    m_reg = (rd ? 16'h0 : m_reg) | (v ? h : 16'h0);
    if (we) m_ctl = wd;
    #1;
    check(req, collide_q, m_reg);
    pix_valid = 1'b0; ctl_we = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic clr();
    step("R9", '0, '0, 1'b0, 1'b0, '0, 1'b1);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    check("R1", collide_q, 16'h0);
    // R1: control is zero, so a pixel with nothing set hits only playfield pair (R5)
    step("R1", 6'b101010, '0, 1'b1, 1'b0, '0, 1'b0);
    check("R5", collide_q, 16'h0001);
    clr();
    // R10: invalid pixel with everything on adds nothing
    step("R10", 6'h3F, 8'hFF, 1'b0, 1'b0, '0, 1'b0);
    check("R10", collide_q, 16'h0000);
    // R3: odd sprite alone without merge makes no group
    step("R3", '0, 8'b0000_0010, 1'b1, 1'b0, '0, 1'b1);
    check("R3", collide_q, 16'h0001);
    // R11/R2: write merge for sprite 1, same-cycle pixel uses old control
    step("R11", '0, 8'b0000_0010, 1'b1, 1'b1, 16'h1000, 1'b1);
    check("R11", collide_q, 16'h0001);
    step("R2", '0, 8'b0000_0010, 1'b1, 1'b0, '0, 1'b1);
    check("R6", collide_q, 16'h0023);
    // R4: include plane 1 (must be 1) and plane 2 (must be 0)
    step("R2", '0, '0, 1'b0, 1'b1, 16'h00C1, 1'b1);
    step("R4", 6'b000000, 8'b0000_0001, 1'b1, 1'b0, '0, 1'b0);
    check("R4", collide_q, 16'h0020);
    clr();
    step("R4", 6'b000001, 8'b0000_0001, 1'b1, 1'b0, '0, 1'b0);
    check("R4", collide_q, 16'h0023);
    clr();
    // R7: groups 2 and 3 only, planes fail both playfields
    step("R7", 6'b000010, 8'b0101_0000, 1'b1, 1'b0, '0, 1'b0);
    check("R7", collide_q, 16'h4000);
    // R8: accumulate another pair without read
    step("R8", 6'b000010, 8'b0000_0101, 1'b1, 1'b0, '0, 1'b0);
    check("R8", collide_q, 16'h4200);
    // R9: read with a simultaneous hit keeps only the new hit
    step("R9", 6'b000010, 8'b0001_0001, 1'b1, 1'b0, '0, 1'b1);
    check("R9", collide_q, 16'h0400);
    clr();
    check("R9", collide_q, 16'h0000);
    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step("R8", r[5:0], r[13:6], r[14] | r[15], (r[23:20] == 4'h0), $urandom, (r[19:17] == 3'b000));
      check("R7", {15'h0, collide_q[15]}, 16'h0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule